// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command nodes stored in a word-organised RAM and streams each node's payload to a downstream command consumer. Every node starts with a header word whose top byte holds the payload length. Its low 24 bits hold the byte address of the next node. The payload words sit directly after the header. A single start pulse with the address of the first node launches the walk. The block reports the total number of words covered, counting one header word plus the payload words for each node.

The block guards against cyclic chains without any side storage. It writes bit 23 of each header it reads back to memory as a visited mark. When it later reads a next pointer that already carries that bit, it stops. The all-ones pointer is the end sentinel, and it carries the bit as well. After the walk stops, a second pass starts again at the first node and follows as many hops as the walk took. It clears the mark in each header it passes, so the chain is left as it was found.

Top module: `ll_walker`

## Requirements
- R1: While reset is asserted, and while idle afterwards, busy_o is low, word_cnt_o is zero after reset, and neither mem_req_o nor cmd_valid_o is asserted.
- R2: A start_i pulse while idle is accepted at that clock edge. After that edge busy_o is high and word_cnt_o reads zero. A start_i pulse while busy has no effect on the walk, the count or memory.
- R3: A node address is reduced to its low 21 bits and divided by four. mem_addr_o carries bits 20:2 of the node address, so address bits 22:21 are ignored. A header word holds the payload length in bits 31:24 and the next node address in bits 23:0.
- R4: The payload words of a node are read from the word indices that follow its header, in increasing order and wrapping modulo the RAM size. Each one is offered on cmd_data_o with cmd_valid_o. cmd_valid_o and cmd_data_o hold steady until cmd_ready_i accepts the word. No memory access happens while a word is offered.
- R5: For each visited node, word_cnt_o grows by one plus that node's payload length.
- R6: The walk ends after a node whose next address is 0xFFFFFF. A start address of 0xFFFFFF visits no node and leaves the count at zero.
- R7: After a header is read, it is written back to the same word with bit 23 set. When the next address taken from a header has bit 23 set, that node is still processed in full and then the walk ends. So a loop back to a node visited earlier processes that node one extra time.
- R8: After the walk, a cleanup pass starts from the first node and follows the same number of hops the walk took between nodes, clearing bit 23 in each header it passes. Memory then matches its prior content, except that the header of the last node processed keeps bit 23 set.
- R9: busy_o stays high from the accepted start until the cleanup pass is done. After that, word_cnt_o holds its final value until the next accepted start.
- R10: A node with a zero payload length produces no transfer on the command port. It still counts one word and moves the walk on to its next node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | 24 | Byte address of the first node |
| busy_o | output | 1 | Walk or cleanup in progress |
| word_cnt_o | output | 32 | Words covered: headers plus payloads |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 19 | Word index into the RAM |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| cmd_valid_o | output | 1 | Payload word offered downstream |
| cmd_data_o | output | 32 | Payload word |
| cmd_ready_i | input | 1 | Downstream accepts the offered word |

## Verification
Loop detection and the end sentinel can both trigger on the same header, because the sentinel has bit 23 set. Both cases must therefore end the walk after that node with the same count. Chains are built that end on the sentinel, that loop back to an earlier node, and that loop back onto themselves. The count, the payload stream and the restored memory are compared against a bench model of each case. A second start pulse can arrive while the walk runs. The bench injects one in the middle of several walks with a different address and checks that the results are unchanged. Random back-pressure on cmd_ready_i stalls the payload stream during the walks.

// File: rtl/ll_walker_pkg.sv
package ll_walker_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HRD,   // header read issued
    ST_HWAIT, // header data back, mark written
    ST_PRD,   // payload read issued
    ST_PWAIT, // payload data back
    ST_PSEND, // payload offered downstream
    ST_HOP,   // decide next node or stop
    ST_CRD,   // cleanup header read issued
    ST_CWAIT, // cleanup header back, mark cleared
    ST_FIN
  } walk_st_e;
endpackage

// File: rtl/ll_addr_map.sv
module ll_addr_map #(
  parameter int unsigned NODE_AW = 24,
  parameter int unsigned MEM_AW  = 21
) (
  input  logic [NODE_AW-1:0] node_addr_i,
  output logic [MEM_AW-3:0]  word_idx_o
);
  // byte address folded into RAM, then to word index
  assign word_idx_o = node_addr_i[MEM_AW-1:2];
endmodule

// File: rtl/ll_word_acc.sv
module ll_word_acc #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (add_i) cnt_o <= cnt_o + CNT_W'(len_i) + CNT_W'(1);
  end
endmodule

// File: rtl/ll_hop_ctr.sv
module ll_hop_ctr #(
  parameter int unsigned HOP_W = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic last_o
);
  logic [HOP_W-1:0] hops_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hops_q <= '0;
    else if (clr_i) hops_q <= '0;
    else if (inc_i) hops_q <= hops_q + HOP_W'(1);
    else if (dec_i) hops_q <= hops_q - HOP_W'(1);
  end

  assign zero_o = (hops_q == '0);
  assign last_o = (hops_q == HOP_W'(1));
endmodule

// File: rtl/ll_walker.sv
module ll_walker
  import ll_walker_pkg::*;
#(
  parameter int unsigned NODE_AW = 24,
  parameter int unsigned MEM_AW  = 21,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned HOP_W   = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [NODE_AW-1:0]        start_addr_i,
  output logic                      busy_o,
  output logic [CNT_W-1:0]          word_cnt_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [MEM_AW-3:0]         mem_addr_o,
  output logic [LEN_W+NODE_AW-1:0]  mem_wdata_o,
  input  logic [LEN_W+NODE_AW-1:0]  mem_rdata_i,
  output logic                      cmd_valid_o,
  output logic [LEN_W+NODE_AW-1:0]  cmd_data_o,
  input  logic                      cmd_ready_i
);
  localparam int unsigned DATA_W = LEN_W + NODE_AW;
  localparam int unsigned IDX_W  = MEM_AW - 2;
  localparam logic [NODE_AW-1:0] SENTINEL = '1;
  localparam logic [DATA_W-1:0]  MARK_W   = DATA_W'(1) << (NODE_AW - 1);

  walk_st_e state_q;
  logic [NODE_AW-1:0] cur_q, nxt_q, first_q;
  logic [LEN_W-1:0]   rem_q;
  logic [IDX_W-1:0]   pidx_q, hdr_idx;
  logic [DATA_W-1:0]  data_q;
  logic               start_go, stop_walk, hop_zero, hop_last;
  logic [LEN_W-1:0]   rd_len;
  logic [NODE_AW-1:0] rd_next;

  assign rd_len    = mem_rdata_i[DATA_W-1 -: LEN_W];
  assign rd_next   = mem_rdata_i[NODE_AW-1:0];
  assign start_go  = (state_q == ST_IDLE) && start_i;
  // sentinel carries the mark bit too; both end the walk
  assign stop_walk = (nxt_q == SENTINEL) || nxt_q[NODE_AW-1];

  ll_addr_map #(.NODE_AW(NODE_AW), .MEM_AW(MEM_AW)) u_map (
    .node_addr_i (cur_q),
    .word_idx_o  (hdr_idx)
  );

  ll_word_acc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_go),
    .add_i  (state_q == ST_HWAIT),
    .len_i  (rd_len),
    .cnt_o  (word_cnt_o)
  );

  ll_hop_ctr #(.HOP_W(HOP_W)) u_hops (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_go),
    .inc_i  ((state_q == ST_HOP) && !stop_walk),
    .dec_i  (state_q == ST_CWAIT),
    .zero_o (hop_zero),
    .last_o (hop_last)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = hdr_idx;
    mem_wdata_o = mem_rdata_i | MARK_W;
    unique case (state_q)
      ST_HRD, ST_CRD: mem_req_o = 1'b1;
      ST_HWAIT: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      ST_CWAIT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = mem_rdata_i & ~MARK_W;
      end
      ST_PRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pidx_q;
      end
      default: ;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign cmd_valid_o = (state_q == ST_PSEND);
  assign cmd_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      first_q <= '0;
      rem_q   <= '0;
      pidx_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q   <= start_addr_i;
          first_q <= start_addr_i;
          state_q <= (start_addr_i == SENTINEL) ? ST_FIN : ST_HRD;
        end
        ST_HRD: state_q <= ST_HWAIT;
        ST_HWAIT: begin
          nxt_q   <= rd_next;
          rem_q   <= rd_len;
          pidx_q  <= hdr_idx + IDX_W'(1);
          state_q <= (rd_len == '0) ? ST_HOP : ST_PRD;
        end
        ST_PRD: state_q <= ST_PWAIT;
        ST_PWAIT: begin
          data_q  <= mem_rdata_i;
          state_q <= ST_PSEND;
        end
        ST_PSEND: if (cmd_ready_i) begin
          rem_q   <= rem_q - LEN_W'(1);
          pidx_q  <= pidx_q + IDX_W'(1);
          state_q <= (rem_q == LEN_W'(1)) ? ST_HOP : ST_PRD;
        end
        ST_HOP: begin
          if (stop_walk) begin
            cur_q   <= first_q;
            state_q <= hop_zero ? ST_FIN : ST_CRD;
          end else begin
            cur_q   <= nxt_q;
            state_q <= ST_HRD;
          end
        end
        ST_CRD: state_q <= ST_CWAIT;
        ST_CWAIT: begin
          cur_q   <= rd_next;
          state_q <= hop_last ? ST_FIN : ST_CRD;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_walker_chk.sv
module ll_walker_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  word_cnt_o,
  input logic              mem_req_o,
  input logic              cmd_valid_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              cmd_ready_i
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !cmd_valid_o); // R1

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && (word_cnt_o == '0)); // R2

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o)); // R4

  AST_NO_MEM_WHILE_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !mem_req_o); // R4

  AST_CNT_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> word_cnt_o >= $past(word_cnt_o)); // R5

  AST_CNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(word_cnt_o)); // R9
endmodule

bind ll_walker ll_walker_chk #(
  .DATA_W (LEN_W + NODE_AW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .word_cnt_o  (word_cnt_o),
  .mem_req_o   (mem_req_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_data_o  (cmd_data_o),
  .cmd_ready_i (cmd_ready_i)
);

// File: tb/ll_walker_tb.sv
module ll_walker_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic        busy_o;
  logic [31:0] word_cnt_o;
  logic        mem_req_o, mem_we_o;
  logic [18:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        cmd_valid_o;
  logic [31:0] cmd_data_o;
  logic        cmd_ready_i = 1'b0;

  always #10 clk = ~clk;

  ll_walker u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_addr_i(start_addr_i),
    .busy_o(busy_o), .word_cnt_o(word_cnt_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i)
  );

  logic [31:0] mem   [int];
  logic [31:0] ref_m [int];
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  int          exp_cnt;
  int          n_chk = 0;
  int          n_fail = 0;

  function automatic logic [31:0] rd_mem(input int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] rd_ref(input int a);
    return ref_m.exists(a) ? ref_m[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // RAM model: request sampled mid-cycle, applied just after the edge
  initial forever begin
    logic r, w;
    logic [18:0] a;
    logic [31:0] d;
    @(negedge clk);
    r = mem_req_o; w = mem_we_o; a = mem_addr_o; d = mem_wdata_o;
    @(posedge clk);
    #1;
    if (r) begin
      if (w) mem[int'(a)] = d;
      else   mem_rdata_i = rd_mem(int'(a));
    end
  end

  initial forever begin
    @(posedge clk);
    #1 cmd_ready_i = ($urandom % 4) != 0;
  end

  initial forever begin
    @(negedge clk);
    if (cmd_valid_o && cmd_ready_i) got_q.push_back(cmd_data_o);
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R9 watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // expected behaviour from the requirements
  function automatic void model(input logic [23:0] sa);
    logic [23:0] a;
    logic [31:0] h;
    int idx, k, len, guard;
    exp_q.delete();
    exp_cnt = 0;
    k = 0;
    a = sa;
    guard = 0;
    if (a != 24'hFFFFFF) begin
      while (guard < 1000) begin
        guard++;
        idx = int'(a[20:2]);
        h = rd_ref(idx);
        len = int'(h[31:24]);
        exp_cnt += 1 + len;
        ref_m[idx] = h | 32'h0080_0000;
        for (int j = 0; j < len; j++) exp_q.push_back(rd_ref((idx + 1 + j) & 32'h7FFFF));
        if (h[23]) break;
        k++;
        a = h[23:0];
      end
    end
    a = sa;
    for (int i = 0; i < k; i++) begin
      idx = int'(a[20:2]);
      h = ref_m[idx];
      ref_m[idx] = h & ~32'h0080_0000;
      a = h[23:0];
    end
  endfunction

  task automatic build(input int n, input int lens[8], input int loop_to,
                       input bit alias_on, output logic [23:0] sa);
    int perm[8];
    int region, t, sw;
    logic [23:0] ba[8];
    mem.delete();
    for (int i = 0; i < 8; i++) perm[i] = i;
    for (int i = 7; i > 0; i--) begin
      sw = int'($urandom % (i + 1));
      t = perm[i]; perm[i] = perm[sw]; perm[sw] = t;
    end
    region = int'($urandom % 1000);
    for (int i = 0; i < n; i++) begin
      int w;
      logic [1:0] al;
      w  = region * 256 + perm[i] * 16 + int'($urandom % 4);
      al = alias_on ? 2'($urandom) : 2'b00;
      ba[i] = {1'b0, al, w[18:0], 2'b00};
    end
    for (int i = 0; i < n; i++) begin
      int w;
      logic [23:0] nx;
      w = int'(ba[i][20:2]);
      if (i < n - 1)      nx = ba[i+1];
      else if (loop_to < 0) nx = 24'hFFFFFF;
      else                nx = ba[loop_to];
      mem[w] = {8'(lens[i]), nx};
      for (int j = 0; j < lens[i]; j++) mem[w + 1 + j] = $urandom;
    end
    sa = ba[0];
  endtask

  task automatic run(input logic [23:0] sa, input bit poke, input string tag);
    int mism, waitc;
    logic [31:0] fin;
    ref_m = mem;
    model(sa);
    got_q.delete();
    @(negedge clk);
    start_i = 1'b1;
    start_addr_i = sa;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R2 busy after start ", tag}, busy_o, 1);
    chk(word_cnt_o == 0, {"R2 count cleared ", tag}, word_cnt_o, 0);
    if (poke) begin
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      start_addr_i = sa ^ 24'h000100;
      @(negedge clk);
      start_i = 1'b0;
    end
    waitc = 0;
    while (busy_o && waitc < 20000) begin
      @(negedge clk);
      waitc++;
    end
    chk(!busy_o, {"R9 busy falls ", tag}, busy_o, 0);
    chk(word_cnt_o == 32'(exp_cnt), {"R5 word count ", tag}, word_cnt_o, exp_cnt);
    chk(got_q.size() == exp_q.size(), {"R4 payload length ", tag}, got_q.size(), exp_q.size());
    mism = 0;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] !== exp_q[i]) mism++;
    chk(mism == 0, {"R4 payload content ", tag}, mism, 0);
    mism = 0;
    foreach (ref_m[k]) if (!mem.exists(k) || mem[k] !== ref_m[k]) mism++;
    if (mem.num() != ref_m.num()) mism++;
    chk(mism == 0, {"R8 memory restored ", tag}, mism, 0);
    fin = word_cnt_o;
    repeat (5) @(negedge clk);
    chk(word_cnt_o == fin && !busy_o, {"R9 count held ", tag}, word_cnt_o, fin);
  endtask

  initial begin
    int lens[8];
    logic [23:0] sa;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy_o && word_cnt_o == 0, "R1 reset idle", {busy_o, word_cnt_o}, 0);
    chk(!mem_req_o && !cmd_valid_o, "R1 reset quiet", {mem_req_o, cmd_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R6: sentinel start visits nothing
    mem.delete();
    mem[5] = 32'h0312_3456;
    run(24'hFFFFFF, 1'b0, "R6 sentinel start");

    // R10: single empty node
    lens = '{0, 0, 0, 0, 0, 0, 0, 0};
    build(1, lens, -1, 1'b0, sa);
    run(sa, 1'b0, "R10 empty node");

    // R3: aliased upper address bits, mixed lengths
    lens = '{2, 0, 3, 0, 0, 0, 0, 0};
    build(3, lens, -1, 1'b1, sa);
    run(sa, 1'b0, "R3 aliased chain");

    // R7: loop back to first node
    lens = '{1, 2, 0, 0, 0, 0, 0, 0};
    build(2, lens, 0, 1'b0, sa);
    run(sa, 1'b0, "R7 loop to head");
    chk(exp_cnt == 7, "R7 loop count model", exp_cnt, 7);

    // R7: node pointing at itself
    lens = '{3, 0, 0, 0, 0, 0, 0, 0};
    build(1, lens, 0, 1'b1, sa);
    run(sa, 1'b0, "R7 self loop");

    // R2: start pulse while busy, long payloads
    lens = '{7, 7, 7, 0, 0, 0, 0, 0};
    build(3, lens, -1, 1'b0, sa);
    run(sa, 1'b1, "R2 start while busy");

    for (int t = 0; t < 30; t++) begin
      int n, lt;
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < 8; i++) lens[i] = int'($urandom % 8);
      lt = (($urandom % 10) < 3) ? int'($urandom % n) : -1;
      build(n, lens, lt, 1'($urandom), sa);
      run(sa, (n >= 2) && ($urandom % 2 == 1), "R5 random chain");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule